// File: doc/BRIEF.md
# Big-Endian Word Memory with Request/Complete Handshake

This block is a byte-addressed memory slave that a processor uses for 32-bit word loads and stores. Every byte location has an address of its own. A word at address `a` is built from the four bytes at `a`, `a+1`, `a+2` and `a+3`. The byte at `a` is the most significant, so byte order is big-endian. Addresses need not be word aligned.

The processor raises exactly one of `rd_req` or `wr_req` together with `addr` and, for a store, `wdata`. The unit samples the request on a rising edge when `ready` is high. On the next cycle it raises `done` for exactly one cycle. `ready` is low while `done` is high, so a request presented in that cycle is not taken. Back-pressure works in one direction only: the requester must hold or re-present its request until it sees `ready` high, because a request made while `ready` is low has no effect. Storage is a synthesizable byte array of `DEPTH` entries, where `DEPTH` is a power of two. Each byte index is taken modulo `DEPTH`, including the three neighbours of a word that straddles the top of the array.

Top module: `mbe_mem_unit`

## Requirements
- R1: During and right after reset, `done` is 0, `ready` is 1, `rdata` is 0 and every stored byte is 0.
- R2: An accepted read with address `a` sets `rdata` to {byte[a], byte[a+1], byte[a+2], byte[a+3]}, with byte[a] in bits 31:24 and byte[a+3] in bits 7:0.
- R3: An accepted write with address `a` stores bits 31:24 at byte `a`, 23:16 at `a+1`, 15:8 at `a+2` and 7:0 at `a+3`, and touches no other byte. Any byte address is allowed, aligned or not.
- R4: Byte indices are computed as (a+k) mod DEPTH for k in 0..3, so a word starting near the top of the array wraps to index 0.
- R5: `done` goes high in the cycle after a request is accepted and stays high for exactly one cycle. It is never high in any other cycle.
- R6: `ready` is low in the cycle that `done` is high. A request presented in that cycle stores nothing and produces no `done`.
- R7: A request with `rd_req` and `wr_req` both high is ignored. It produces no `done`, changes no stored byte and leaves `rdata` as it was.
- R8: `rdata` keeps its value from the `done` of a read until the next accepted read. Accepted writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| addr | input | ADDR_W | Byte address of the word's most significant byte |
| wdata | input | 32 | Word to store, big-endian |
| ready | output | 1 | High when a request will be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Word returned by the last read |

## Verification
Directed loads and stores at aligned, unaligned and top-of-array addresses separate correct big-endian byte lanes and correct modulo wrap from swapped lanes or a missing wrap. A long run of random reads and writes, with addresses biased toward the top of the array, is compared against a byte model kept in the bench. This run shows up any stray write into a neighbouring byte. Requests held through the busy cycle, and requests with both read and write high, each check that the request is dropped: the next completion slot and a later read-back show whether anything was stored or signalled. Writes placed between reads show whether `rdata` is kept or overwritten.

// File: rtl/mbe_pkg.sv
package mbe_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_BAD   = 2'b11
  } op_e;
endpackage

// File: rtl/mbe_lane_addr.sv
module mbe_lane_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [IDX_W-1:0]   idx [mbe_pkg::LANES]
);
  // Lane k (k = 0 is the most significant byte) maps to (addr + k) mod DEPTH.
  for (genvar k = 0; k < int'(mbe_pkg::LANES); k++) begin : g_lane
    logic [ADDR_W-1:0] sum;
    always_comb begin
      sum    = addr + ADDR_W'(k);
      idx[k] = IDX_W'(sum % ADDR_W'(DEPTH));
    end
  end
endmodule

// File: rtl/mbe_store.sv
module mbe_store #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_W-1:0]     idx    [mbe_pkg::LANES],
  input  mbe_pkg::byte_t       wbytes [mbe_pkg::LANES],
  output mbe_pkg::byte_t       rbytes [mbe_pkg::LANES]
);
  mbe_pkg::byte_t cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) cells[i] <= '0;
    end else if (we) begin
      for (int k = 0; k < int'(mbe_pkg::LANES); k++) cells[idx[k]] <= wbytes[k];
    end
  end

  for (genvar k = 0; k < int'(mbe_pkg::LANES); k++) begin : g_rd
    assign rbytes[k] = cells[idx[k]];
  end
endmodule

// File: rtl/mbe_ctrl.sv
module mbe_ctrl (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_req,
  input  logic                           wr_req,
  input  mbe_pkg::byte_t                 rbytes [mbe_pkg::LANES],
  output logic                           ready,
  output logic                           done,
  output logic                           we,
  output logic [mbe_pkg::WORD_W-1:0]     rdata
);
  import mbe_pkg::*;

  op_e  op;
  logic take;
  logic [WORD_W-1:0] joined;

  assign op    = op_e'({rd_req, wr_req});
  assign ready = !done;
  assign take  = ready && (op == OP_READ || op == OP_WRITE);
  assign we    = take && (op == OP_WRITE);

  for (genvar k = 0; k < int'(LANES); k++) begin : g_join
    assign joined[WORD_W-1-k*BYTE_W -: BYTE_W] = rbytes[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= take;
      if (take && op == OP_READ) rdata <= joined;
    end
  end
endmodule

// File: rtl/mbe_mem_unit.sv
module mbe_mem_unit #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              ready,
  output logic              done,
  output logic [31:0]       rdata
);
  import mbe_pkg::*;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] idx    [LANES];
  byte_t            wbytes [LANES];
  byte_t            rbytes [LANES];
  logic             we;

  for (genvar k = 0; k < int'(LANES); k++) begin : g_split
    assign wbytes[k] = wdata[WORD_W-1-k*BYTE_W -: BYTE_W];
  end

  mbe_lane_addr #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_lanes (
    .addr (addr),
    .idx  (idx)
  );

  mbe_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we),
    .idx    (idx),
    .wbytes (wbytes),
    .rbytes (rbytes)
  );

  mbe_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_req (rd_req),
    .wr_req (wr_req),
    .rbytes (rbytes),
    .ready  (ready),
    .done   (done),
    .we     (we),
    .rdata  (rdata)
  );
endmodule

// File: rtl/mbe_mem_unit_chk.sv
module mbe_mem_unit_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              wr_req,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              ready,
  input logic              done,
  input logic [31:0]       rdata
);
  logic acc;
  assign acc = ready && (rd_req != wr_req);

  // R1
  a_r1_reset_state: assert property (@(posedge clk) !rst_n |=> (!done && ready));
  // R5
  a_r5_done_follows: assert property (@(posedge clk) disable iff (!rst_n) acc |=> done);
  a_r5_done_single:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r5_no_spurious:  assert property (@(posedge clk) disable iff (!rst_n) !acc |=> !done);
  // R6
  a_r6_busy_blocks:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !ready);
  // R7
  a_r7_conflict_ign: assert property (@(posedge clk) disable iff (!rst_n)
                                      (rd_req && wr_req) |=> (!done && $stable(rdata)));
  // R8
  a_r8_rdata_hold:   assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(rdata));
  a_r8_write_keeps:  assert property (@(posedge clk) disable iff (!rst_n)
                                      (acc && wr_req) |=> $stable(rdata));
endmodule

bind mbe_mem_unit mbe_mem_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_req (rd_req),
  .wr_req (wr_req),
  .addr   (addr),
  .wdata  (wdata),
  .ready  (ready),
  .done   (done),
  .rdata  (rdata)
);

// File: tb/sim_mbe_mem_unit.sv
module sim_mbe_mem_unit;
  localparam int unsigned DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0, wr_req = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        ready, done;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0]  model [DEPTH];
  logic [31:0] last_rd = '0;

  always #10 clk = ~clk;

  mbe_mem_unit #(.ADDR_W(32), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .addr(addr), .wdata(wdata), .ready(ready), .done(done), .rdata(rdata)
  );

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) w = {w[23:0], model[(a + k) % DEPTH]};
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a negedge; one clock later the completion is sampled.
  task automatic access(input logic rd, input logic [31:0] a, input logic [31:0] d);
    check("R6 ready before request", {31'd0, ready}, 32'd1);
    rd_req = rd; wr_req = !rd; addr = a; wdata = d;
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0;
    check("R5 done after accept", {31'd0, done}, 32'd1);
    if (rd) begin
      check("R2/R4 read word", rdata, exp_word(a));
      last_rd = rdata;
    end else begin
      for (int k = 0; k < 4; k++) model[(a + k) % DEPTH] = d[31-8*k -: 8];
      check("R8 write keeps rdata", rdata, last_rd);
    end
    @(negedge clk);
    check("R5 single pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < int'(DEPTH); i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 done in reset", {31'd0, done}, 32'd0);
    check("R1 ready in reset", {31'd0, ready}, 32'd1);
    check("R1 rdata in reset", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: stored bytes zero
    access(1'b1, 32'h0000_0010, '0);
    access(1'b1, 32'h0000_00FE, '0);

    // R3: aligned and unaligned big-endian stores
    access(1'b0, 32'h0000_0020, 32'h1122_3344);
    access(1'b1, 32'h0000_0020, '0);
    access(1'b1, 32'h0000_0021, '0);
    access(1'b0, 32'h0000_0043, 32'hA1B2_C3D4);
    access(1'b1, 32'h0000_0042, '0);
    access(1'b1, 32'h0000_0044, '0);

    // R4: wrap across top of array and high address bits
    access(1'b0, 32'h0000_00FE, 32'hCAFE_BEEF);
    access(1'b1, 32'h0000_0000, '0);
    access(1'b1, 32'hFFFF_FFFE, '0);
    access(1'b1, 32'h1234_56FD, '0);

    // R6: request held into busy cycle is dropped
    rd_req = 1'b1; addr = 32'h20;
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b1; addr = 32'h60; wdata = 32'hDEAD_0001;
    check("R6 ready low while done", {31'd0, ready}, 32'd0);
    @(negedge clk);
    wr_req = 1'b0;
    check("R6 no done for blocked request", {31'd0, done}, 32'd0);
    last_rd = rdata;
    access(1'b1, 32'h60, '0);

    // R7: read and write together
    rd_req = 1'b1; wr_req = 1'b1; addr = 32'h70; wdata = 32'h5555_AAAA;
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0;
    check("R7 no done on conflict", {31'd0, done}, 32'd0);
    check("R7 rdata unchanged", rdata, last_rd);
    access(1'b1, 32'h70, '0);

    // Random mix, addresses biased toward the top
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom % 3 == 0) a[7:0] = 8'hFC | a[1:0];
      access(($urandom % 2) == 0, a, $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule